// File: doc/BRIEF.md
# Wrapping Interrupt Down-Counter

This block is a timer that raises a level interrupt request after a programmed number of processor cycles. Software loads a 16-bit count one byte at a time, then enables counting. Each processor cycle, signalled by a one-cycle enable pulse, lowers the count by one. When the count steps below zero and wraps from 0x0000 to 0xFFFF, the interrupt line takes the value of the interrupt enable. Counting then carries on from 0xFFFF.

Address decoding lives outside the block. A separate decoder supplies one write strobe per register and a shared data byte. There are three registers: a control register, a low count byte and a high count byte. The counter and the interrupt output have separate enable bits. Writing the control register with the interrupt enable cleared acknowledges a pending request.

The asynchronous active-low reset is released synchronously inside the block. After `rst_n` rises, the block ignores register writes and ticks for two clock cycles.

Top module: `irq_down_timer`

## Requirements
- R1: A control write (`ctrl_we`) loads the interrupt enable from `wdata[7]` and the count enable from `wdata[0]`. The other data bits are ignored.
- R2: A control write with `wdata[7]` = 0 drives `irq` low on the same clock edge. This also applies in a cycle where a wrap occurs.
- R3: A low-byte write (`lo_we`) replaces count bits 7:0 with `wdata` and leaves bits 15:8 unchanged.
- R4: A high-byte write (`hi_we`) replaces count bits 15:8 with `wdata` and leaves bits 7:0 unchanged. If both strobes are high, both bytes take `wdata`.
- R5: While the count enable that is already registered is set, each cycle with `cpu_tick` high lowers the count by one. With `cpu_tick` low or the count enable clear, the count holds.
- R6: A decrement from 0x0000 gives 0xFFFF and sets `irq` to the registered interrupt enable. Counting carries on from 0xFFFF, so the next wrap comes 65536 ticks later.
- R7: `irq` keeps its value in every cycle that has neither a wrap nor a control write with `wdata[7]` = 0.
- R8: In a cycle with a byte write (R3 or R4) and a tick, the written value is stored as given and no decrement takes place.
- R9: Reset clears the count, both enables and `irq`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ctrl_we | input | 1 | Control register write strobe |
| lo_we | input | 1 | Low count byte write strobe |
| hi_we | input | 1 | High count byte write strobe |
| wdata | input | 8 | Register write data |
| cpu_tick | input | 1 | One pulse per processor cycle |
| irq | output | 1 | Level interrupt request |

## Verification
Every result is registered. A write, a tick or a wrap takes effect on the clock edge that samples it, and `irq` shows that effect from then until the next edge. The count is not visible at the ports, so the bench infers the stored count from the tick on which `irq` rises. A cycle model in the bench, updated on the same edge, is compared with `irq` on every falling edge. Directed checks are sampled one cycle after their last stimulus. Tick counts are placed one short of the expected wrap and exactly on it, so an off-by-one load or decrement shows up as a miss on one side.

// File: rtl/irq_timer_pkg.sv
package irq_timer_pkg;
  localparam int unsigned CNT_W  = 16;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned IEN_BIT = 7;
  localparam int unsigned CEN_BIT = 0;

  typedef struct packed {
    logic irq_en;
    logic cnt_en;
  } timer_ctrl_t;
endpackage

// File: rtl/irq_timer_rst_sync.sv
module irq_timer_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= {pipe_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = pipe_q[STAGES-1];
endmodule

// File: rtl/irq_timer_ctrl.sv
module irq_timer_ctrl
  import irq_timer_pkg::*;
#(
  parameter int unsigned DATA_W = BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_we,
  input  logic [DATA_W-1:0] wdata,
  output timer_ctrl_t       ctrl_q
);
  timer_ctrl_t ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_we) begin
      ctrl_d.irq_en = wdata[IEN_BIT];
      ctrl_d.cnt_en = wdata[CEN_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  assert_ctrl_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we |=> (ctrl_q.irq_en == $past(wdata[IEN_BIT])) && (ctrl_q.cnt_en == $past(wdata[CEN_BIT])));
  assert_ctrl_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_we |=> $stable(ctrl_q));
endmodule

// File: rtl/irq_timer_counter.sv
module irq_timer_counter
  import irq_timer_pkg::*;
#(
  parameter int unsigned WIDTH  = CNT_W,
  parameter int unsigned LANE_W = BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WIDTH/LANE_W-1:0] lane_we,
  input  logic [LANE_W-1:0] wdata,
  input  logic              dec_req,
  output logic              wrap
);
  localparam int unsigned LANES = WIDTH / LANE_W;

  logic [WIDTH-1:0] cnt_q;
  logic [WIDTH-1:0] cnt_d;
  logic             any_we;
  logic             dec_go;

  assign any_we = |lane_we;
  assign dec_go = dec_req && !any_we;
  assign wrap   = dec_go && (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    if (dec_go) cnt_d = cnt_q - 1'b1;
    for (int i = 0; i < LANES; i++) begin
      if (lane_we[i]) cnt_d[i*LANE_W +: LANE_W] = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane_chk
      assert_lane_untouched_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (any_we && !lane_we[g]) |=> cnt_q[g*LANE_W +: LANE_W] == $past(cnt_q[g*LANE_W +: LANE_W]));
      assert_lane_loaded_R4: assert property (@(posedge clk) disable iff (!rst_n)
        lane_we[g] |=> cnt_q[g*LANE_W +: LANE_W] == $past(wdata));
    end
  endgenerate

  assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!dec_req && !any_we) |=> $stable(cnt_q));
  assert_step_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_req && !any_we) |=> cnt_q == $past(cnt_q) - 1'b1);
  assert_wrap_all_ones_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> &cnt_q);
endmodule

// File: rtl/irq_timer_flag.sv
module irq_timer_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic ack,
  input  logic wrap,
  input  logic irq_en,
  output logic irq
);
  logic irq_d;

  always_comb begin
    irq_d = irq;
    if (ack)       irq_d = 1'b0;
    else if (wrap) irq_d = irq_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= irq_d;
  end

  assert_ack_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !irq);
  assert_wrap_follows_en_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && !ack) |=> irq == $past(irq_en));
  assert_quiet_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!wrap && !ack) |=> $stable(irq));
endmodule

// File: rtl/irq_down_timer.sv
module irq_down_timer
  import irq_timer_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctrl_we,
  input  logic       lo_we,
  input  logic       hi_we,
  input  logic [7:0] wdata,
  input  logic       cpu_tick,
  output logic       irq
);
  localparam int unsigned LANES = CNT_W / BYTE_W;

  logic             rst_n_sync;
  timer_ctrl_t      ctrl_q;
  logic [LANES-1:0] lane_we;
  logic             wrap;
  logic             ack;

  irq_timer_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  irq_timer_ctrl #(.DATA_W(BYTE_W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .ctrl_we (ctrl_we),
    .wdata   (wdata),
    .ctrl_q  (ctrl_q)
  );

  assign lane_we = {hi_we, lo_we};
  assign ack     = ctrl_we && !wdata[IEN_BIT];

  irq_timer_counter #(.WIDTH(CNT_W), .LANE_W(BYTE_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .lane_we (lane_we),
    .wdata   (wdata),
    .dec_req (ctrl_q.cnt_en && cpu_tick),
    .wrap    (wrap)
  );

  irq_timer_flag u_flag (
    .clk    (clk),
    .rst_n  (rst_n_sync),
    .ack    (ack),
    .wrap   (wrap),
    .irq_en (ctrl_q.irq_en),
    .irq    (irq)
  );

  assert_rise_needs_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n_sync)
    $rose(irq) |-> $past(wrap));
  assert_no_wrap_on_write_R8: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (lo_we || hi_we) |-> !wrap);
  always_comb begin
    if (!rst_n) assert_reset_low_R9: assert (!irq);
  end
endmodule

// File: tb/tb_irq_down_timer.sv
module tb_irq_down_timer;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       ctrl_we, lo_we, hi_we, cpu_tick;
  logic [7:0] wdata;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int m_cnt, m_ien, m_cen, m_irq;

  irq_down_timer dut (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .lo_we(lo_we),
    .hi_we(hi_we), .wdata(wdata), .cpu_tick(cpu_tick), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model, updated on the same edge the design samples
  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_ien = 0; m_cen = 0; m_irq = 0;
    end else begin
      int dec, wrp;
      dec = (m_cen != 0 && cpu_tick && !lo_we && !hi_we) ? 1 : 0;
      wrp = (dec != 0 && m_cnt == 0) ? 1 : 0;
      if (ctrl_we && !wdata[7]) m_irq = 0;
      else if (wrp != 0)        m_irq = m_ien;
      if (lo_we || hi_we) begin
        if (lo_we) m_cnt = (m_cnt & 'hFF00) | wdata;
        if (hi_we) m_cnt = (m_cnt & 'h00FF) | (int'(wdata) << 8);
      end else if (dec != 0) m_cnt = (m_cnt - 1) & 'hFFFF;
      if (ctrl_we) begin m_ien = wdata[7]; m_cen = wdata[0]; end
    end
  end

  // every-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (irq !== m_irq[0]) begin
        errors++;
        $display("FAIL R5 R6 R7 model compare t=%0t irq actual=%0b expected=%0b", $time, irq, m_irq[0]);
      end
    end
  end

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic step(input logic c, input logic l, input logic h,
                      input logic [7:0] d, input logic t);
    ctrl_we = c; lo_we = l; hi_we = h; wdata = d; cpu_tick = t;
    @(posedge clk); #1;
    ctrl_we = 0; lo_we = 0; hi_we = 0; wdata = 0; cpu_tick = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 8'h00, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 300000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 0; ctrl_we = 0; lo_we = 0; hi_we = 0; wdata = 0; cpu_tick = 0;
    repeat (3) @(posedge clk);
    #1 check("R9 irq low in reset", irq, 1'b0);
    rst_n = 1;
    repeat (4) step(0, 0, 0, 8'h00, 1);
    check("R9 irq low after reset", irq, 1'b0);

    // R5: count enable off, ticks do nothing
    step(1, 0, 0, 8'h80, 0);
    ticks(5);
    check("R5 no count while disabled", irq, 1'b0);

    // R1 R6: load 2, enable with extra bits set; wrap on the 3rd tick
    step(0, 1, 0, 8'h02, 0);
    step(0, 0, 1, 8'h00, 0);
    step(1, 0, 0, 8'hFF, 0);
    ticks(2);
    check("R6 not yet wrapped", irq, 1'b0);
    ticks(1);
    check("R1 R6 wrap raises irq", irq, 1'b1);
    repeat (6) step(0, 0, 0, 8'h00, 0);
    check("R7 irq holds without events", irq, 1'b1);

    // R2: acknowledge, counting keeps running
    step(1, 0, 0, 8'h01, 1);
    check("R2 ack drops irq", irq, 1'b0);

    // R3: 0x0100 then low byte 0x02 -> 0x0102, wrap on tick 259
    step(1, 0, 0, 8'h80, 0);
    step(0, 0, 1, 8'h01, 0);
    step(0, 1, 0, 8'h00, 0);
    step(0, 1, 0, 8'h02, 0);
    step(1, 0, 0, 8'h81, 0);
    ticks(258);
    check("R3 one short of wrap", irq, 1'b0);
    ticks(1);
    check("R3 high byte kept", irq, 1'b1);

    // R4 R8: writes during ticks; low 0x05, high 0x00 -> 0x0005, wrap on tick 6
    step(1, 0, 0, 8'h01, 0);
    step(0, 0, 1, 8'h07, 1);
    step(0, 1, 0, 8'h05, 1);
    step(0, 0, 1, 8'h00, 1);
    step(1, 0, 0, 8'h81, 0);
    ticks(5);
    check("R4 R8 one short of wrap", irq, 1'b0);
    ticks(1);
    check("R4 R8 wrap after loaded value", irq, 1'b1);

    // R6: continues from 0xFFFF, next wrap 65536 ticks later
    step(1, 0, 0, 8'h01, 1);
    step(1, 0, 0, 8'h81, 1);
    ticks(65533);
    check("R6 before second wrap", irq, 1'b0);
    ticks(1);
    check("R6 second wrap after 65536 ticks", irq, 1'b1);

    // R6: wrap with interrupt enable clear leaves irq low
    step(1, 0, 0, 8'h01, 0);
    step(0, 1, 0, 8'h01, 0);
    step(0, 0, 1, 8'h00, 0);
    ticks(2);
    check("R6 wrap with enable clear", irq, 1'b0);

    // R2: ack in the wrap cycle wins
    step(0, 1, 0, 8'h00, 0);
    step(0, 0, 1, 8'h00, 0);
    step(1, 0, 0, 8'h81, 0);
    step(1, 0, 0, 8'h01, 1);
    check("R2 ack beats wrap", irq, 1'b0);

    // random phase against the model
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 4)       step(1, 0, 0, 8'($urandom) | 8'h01, $urandom_range(0, 1));
      else if (r < 6)  step(1, 0, 0, 8'($urandom), $urandom_range(0, 1));
      else if (r < 9)  step(0, 1, 0, 8'($urandom_range(0, 12)), $urandom_range(0, 1));
      else if (r < 12) step(0, 0, 1, 8'h00, $urandom_range(0, 1));
      else if (r < 13) step(0, 1, 1, 8'h00, 1);
      else             step(0, 0, 0, 8'($urandom), $urandom_range(0, 3) != 0);
    end

    rst_n = 0;
    #1 check("R9 async reset clears irq", irq, 1'b0);
    @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule